// File: doc/BRIEF.md
# Instruction Byte Prefetch Queue

This block sits between a 16-bit instruction fetch path and a decoder that consumes one byte at a time. It keeps up to six bytes in arrival order and asks for another word as soon as two slots are free, so memory keeps streaming while the decoder works. A returned word normally adds two bytes, low byte first. When the fetch address is odd, only the upper byte is kept and the fetch address moves on by one, which leaves later fetches word aligned.

The consumer sees a byte whenever the queue holds one. If the queue is empty, a byte arriving from memory is handed to the consumer in that same cycle. A branch flush throws away the contents, cancels any fetch still outstanding (its data is dropped on return), and restarts fetching at the branch target. A registered two-bit status code reports what the queue did in the previous clock, so external logic can follow the queue.

Top module: `pfq_top`

## Requirements
- R1: After reset the queue is empty (`cons_vld` low), `qstat` is 00, `fetch_addr` equals the `RESET_ADDR` parameter (default 20'hFFFF0) and `fetch_req` is high.
- R2: Bytes reach the consumer in exactly the order they were loaded.
- R3: `fetch_req` is high exactly when no fetch is outstanding and at least two of the six slots are free. A fetch is outstanding from the cycle `fetch_ack` is seen with `fetch_req` until the cycle `rdata_vld` is seen.
- R4: On an accepted fetch at an even address, the returned word adds bits 7:0 then bits 15:8 and `fetch_addr` steps by 2; at an odd address only bits 15:8 are added and `fetch_addr` steps by 1.
- R5: With the queue empty, the first byte of a returning word drives `cons_byte` with `cons_vld` high in the same cycle and can be taken in that cycle.
- R6: A take and a two-byte load in the same clock are both applied, and `cons_vld` tracks the resulting occupancy.
- R7: One clock after a byte is taken, `qstat` is 01 if `cons_first` was high with the take and 11 otherwise.
- R8: One clock after a cycle with neither a take nor a flush, `qstat` is 00.
- R9: A flush empties the queue, makes `qstat` 10 in the next clock, loads `fetch_addr` from `flush_addr`, and causes data of a fetch accepted before or during the flush to be dropped; a take or a returning word in the flush cycle has no effect.
- R10: Occupancy never exceeds six; with five or more bytes held, `fetch_req` stays low.
- R11: `fetch_seg` reports the code-segment tag 10 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | output | 1 | Word fetch request |
| fetch_addr | output | 20 | Byte address of the requested word fetch |
| fetch_seg | output | 2 | Segment tag for the fetch, always 10 (code) |
| fetch_ack | input | 1 | Fetch accepted (counts only while `fetch_req` is high) |
| rdata_vld | input | 1 | Fetched word present (counts only while a fetch is outstanding) |
| rdata | input | 16 | Fetched word |
| flush | input | 1 | Branch flush |
| flush_addr | input | 20 | Branch target byte address |
| cons_take | input | 1 | Consumer takes the offered byte |
| cons_first | input | 1 | Taken byte starts an instruction |
| cons_vld | output | 1 | A byte is offered |
| cons_byte | output | 8 | Offered byte |
| qstat | output | 2 | Queue status of the previous clock: 00 idle, 01 first byte, 10 flushed, 11 later byte |

## Verification
A reference model in the bench is driven with seeded random mixes of fetch acknowledges, data returns (some arriving with no fetch outstanding), takes with and without the first-byte flag, and flushes to random targets. Odd flush targets separate the single-byte load path from the word path, and frequent takes against slow returns keep the queue empty, which exercises the same-cycle bypass. Long stretches with no takes fill the queue and show whether the refill threshold holds off requests. Flushes landing while a fetch is outstanding, or in the very cycle of a return, show whether stale data is dropped.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  typedef enum logic [1:0] {
    QS_IDLE  = 2'b00,
    QS_FIRST = 2'b01,
    QS_FLUSH = 2'b10,
    QS_NEXT  = 2'b11
  } qstat_e;

  localparam logic [1:0] SEG_CODE = 2'b10;
endpackage

// File: rtl/pfq_store.sv
module pfq_store #(
  parameter int DEPTH = 6,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [1:0]    push_n,
  input  logic [7:0]    b0,
  input  logic [7:0]    b1,
  input  logic          pop,
  output logic [CW-1:0] cnt,
  output logic [7:0]    head
);
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] rd_q, wr_q, rd_d, wr_d, wr_p1;
  logic [CW-1:0] cnt_d;

  function automatic logic [PW-1:0] wrap_add(input logic [PW-1:0] p, input int unsigned k);
    logic [PW:0] s;
    s = {1'b0, p} + (PW+1)'(k);
    if (s >= (PW+1)'(DEPTH)) s = s - (PW+1)'(DEPTH);
    return s[PW-1:0];
  endfunction

  always_comb begin
    wr_p1 = wrap_add(wr_q, 1);
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt;
    if (clr) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      wr_d  = wrap_add(wr_q, push_n);
      rd_d  = pop ? wrap_add(rd_q, 1) : rd_q;
      cnt_d = CW'(cnt + CW'(push_n) - CW'(pop));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
      wr_q <= '0;
      cnt  <= '0;
    end else begin
      rd_q <= rd_d;
      wr_q <= wr_d;
      cnt  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!clr && push_n != 2'd0) mem[wr_q] <= b0;
    if (!clr && push_n == 2'd2) mem[wr_p1] <= b1;
  end

  assign head = mem[rd_q];

  // R10
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch #(
  parameter int          AW         = 20,
  parameter logic [AW-1:0] RESET_ADDR = 20'hFFFF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          room,
  input  logic          flush,
  input  logic [AW-1:0] flush_addr,
  input  logic          fetch_ack,
  input  logic          rdata_vld,
  input  logic [15:0]   rdata,
  output logic          fetch_req,
  output logic [AW-1:0] fetch_addr,
  output logic [1:0]    arr_n,
  output logic [7:0]    arr_b0,
  output logic [7:0]    arr_b1
);
  logic          pend_q, stale_q, podd_q;
  logic          pend_d, stale_d, podd_d;
  logic [AW-1:0] addr_d;
  logic          take_word, accept;

  assign fetch_req = room && !pend_q;
  assign accept    = fetch_req && fetch_ack;
  assign take_word = pend_q && rdata_vld;
  assign arr_n     = (take_word && !stale_q) ? (podd_q ? 2'd1 : 2'd2) : 2'd0;
  assign arr_b0    = podd_q ? rdata[15:8] : rdata[7:0];
  assign arr_b1    = rdata[15:8];

  always_comb begin
    pend_d  = pend_q;
    stale_d = stale_q;
    podd_d  = podd_q;
    addr_d  = fetch_addr;
    if (take_word) begin
      pend_d  = 1'b0;
      stale_d = 1'b0;
    end else if (accept) begin
      pend_d  = 1'b1;
      stale_d = flush;
      podd_d  = fetch_addr[0];
    end else if (flush && pend_q) begin
      stale_d = 1'b1;
    end
    if (flush)       addr_d = flush_addr;
    else if (accept) addr_d = fetch_addr + (fetch_addr[0] ? AW'(1) : AW'(2));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      stale_q    <= 1'b0;
      podd_q     <= 1'b0;
      fetch_addr <= RESET_ADDR;
    end else begin
      pend_q     <= pend_d;
      stale_q    <= stale_d;
      podd_q     <= podd_d;
      fetch_addr <= addr_d;
    end
  end

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_ack && !flush) |=>
      fetch_addr == $past(fetch_addr) + ($past(fetch_addr[0]) ? AW'(1) : AW'(2)));
  // R9
  flush_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> fetch_addr == $past(flush_addr));
endmodule

// File: rtl/pfq_status.sv
module pfq_status
  import pfq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       popped,
  input  logic       first,
  output logic [1:0] qstat
);
  qstat_e qs_d;

  always_comb begin
    if (flush)       qs_d = QS_FLUSH;
    else if (popped) qs_d = first ? QS_FIRST : QS_NEXT;
    else             qs_d = QS_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qstat <= QS_IDLE;
    else        qstat <= qs_d;
  end
endmodule

// File: rtl/pfq_top.sv
module pfq_top
  import pfq_pkg::*;
#(
  parameter int            DEPTH      = 6,
  parameter int            AW         = 20,
  parameter logic [AW-1:0] RESET_ADDR = 20'hFFFF0,
  localparam int           CW         = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          fetch_req,
  output logic [AW-1:0] fetch_addr,
  output logic [1:0]    fetch_seg,
  input  logic          fetch_ack,
  input  logic          rdata_vld,
  input  logic [15:0]   rdata,
  input  logic          flush,
  input  logic [AW-1:0] flush_addr,
  input  logic          cons_take,
  input  logic          cons_first,
  output logic          cons_vld,
  output logic [7:0]    cons_byte,
  output logic [1:0]    qstat
);
  localparam logic [CW-1:0] REFILL_LIM = CW'(DEPTH - 2);

  logic [CW-1:0] cnt;
  logic [7:0]    head, b0, b1;
  logic [1:0]    arr_n, push_n;
  logic          room, popped;

  assign room      = cnt <= REFILL_LIM;
  assign cons_vld  = (cnt != '0) || (arr_n != 2'd0);
  assign cons_byte = (cnt != '0) ? head : b0;
  assign popped    = cons_take && cons_vld && !flush;
  assign push_n    = flush ? 2'd0 : arr_n;
  assign fetch_seg = SEG_CODE;

  pfq_fetch #(.AW(AW), .RESET_ADDR(RESET_ADDR)) u_fetch (
    .clk(clk), .rst_n(rst_n), .room(room), .flush(flush), .flush_addr(flush_addr),
    .fetch_ack(fetch_ack), .rdata_vld(rdata_vld), .rdata(rdata),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .arr_n(arr_n), .arr_b0(b0), .arr_b1(b1));

  pfq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(flush), .push_n(push_n), .b0(b0), .b1(b1),
    .pop(popped), .cnt(cnt), .head(head));

  pfq_status u_status (
    .clk(clk), .rst_n(rst_n), .flush(flush), .popped(popped),
    .first(cons_first), .qstat(qstat));

  // R3
  refill_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> cnt <= REFILL_LIM);
  // R7
  take_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_take && cons_vld && !flush) |=> qstat[0]);
  // R8
  idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !(cons_take && cons_vld)) |=> qstat == 2'b00);
  // R9
  flush_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> qstat == 2'b10);
endmodule

// File: tb/pfq_top_bench.sv
module pfq_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_req, fetch_ack, rdata_vld, flush, cons_take, cons_first, cons_vld;
  logic [19:0] fetch_addr, flush_addr;
  logic [1:0]  fetch_seg, qstat;
  logic [15:0] rdata;
  logic [7:0]  cons_byte;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pfq_top u_pfq_top (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_seg(fetch_seg), .fetch_ack(fetch_ack), .rdata_vld(rdata_vld), .rdata(rdata),
    .flush(flush), .flush_addr(flush_addr), .cons_take(cons_take), .cons_first(cons_first),
    .cons_vld(cons_vld), .cons_byte(cons_byte), .qstat(qstat));

  // model state
  byte unsigned q[$];
  bit          m_pend, m_stale;
  logic [19:0] m_addr, m_faddr;
  logic [1:0]  m_qs;

  function automatic logic [7:0] mem_byte(input logic [19:0] a);
    return a[7:0] ^ (a[15:8] * 8'd3) ^ {4'h0, a[19:16]} ^ 8'h5A;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1d2c);
    rst_n = 0; fetch_ack = 0; rdata_vld = 0; rdata = 0; flush = 0; flush_addr = 0;
    cons_take = 0; cons_first = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    check("R1 cons_vld", cons_vld, 0);
    check("R1 qstat", qstat, 0);
    check("R1 fetch_addr", fetch_addr, 20'hFFFF0);
    check("R1 fetch_req", fetch_req, 1);
    m_pend = 0; m_stale = 0; m_addr = 20'hFFFF0; m_faddr = 0; m_qs = 0;

    for (int cyc = 0; cyc < 6000; cyc++) begin
      int nb;
      bit incoming, exp_vld, exp_req, popped, acc;
      byte unsigned bs[2];
      bit fill_phase;
      @(negedge clk);
      fill_phase = (cyc % 500) >= 440;   // long stretches without takes
      fetch_ack  = ($urandom % 2) == 0;
      rdata_vld  = ($urandom % 3) == 0;
      flush      = (cyc % 500 == 20) ? 1'b1 : (($urandom % 24) == 0);
      flush_addr = $urandom;
      if (cyc % 500 == 60) flush_addr[0] = 1'b1;   // odd target corner
      cons_take  = fill_phase ? 1'b0 : ((cyc % 200) < 100 ? 1'b1 : ($urandom % 2 == 0));
      cons_first = ($urandom % 3) == 0;
      rdata      = {mem_byte({m_faddr[19:1], 1'b1}), mem_byte({m_faddr[19:1], 1'b0})};
      #1;
      incoming = rdata_vld && m_pend && !m_stale;
      nb = incoming ? (m_faddr[0] ? 1 : 2) : 0;
      if (m_faddr[0]) bs[0] = rdata[15:8]; else bs[0] = rdata[7:0];
      bs[1] = rdata[15:8];
      exp_vld = (q.size() > 0) || (nb > 0);
      exp_req = !m_pend && (q.size() <= 4);

      check("R3 fetch_req", fetch_req, exp_req);
      if (q.size() >= 5) check("R10 fetch_req held low", fetch_req, 0);
      check("R4 fetch_addr", fetch_addr, m_addr);
      check("R6 cons_vld", cons_vld, exp_vld);
      if (exp_vld) check(q.size() == 0 ? "R5 bypass byte" : "R2 byte order", cons_byte,
                         q.size() > 0 ? q[0] : bs[0]);
      check(m_qs == 2 ? "R9 qstat" : (m_qs == 0 ? "R8 qstat" : "R7 qstat"), qstat, m_qs);
      check("R11 fetch_seg", fetch_seg, 2'b10);

      // model update
      popped = cons_take && exp_vld && !flush;
      acc = exp_req && fetch_ack;
      m_qs = flush ? 2'd2 : (popped ? (cons_first ? 2'd1 : 2'd3) : 2'd0);
      if (flush) q.delete();
      else begin
        for (int k = 0; k < nb; k++) q.push_back(bs[k]);
        if (popped) void'(q.pop_front());
      end
      if (m_pend && rdata_vld) begin m_pend = 0; m_stale = 0; end
      else if (acc) begin m_pend = 1; m_stale = flush; m_faddr = m_addr; end
      else if (flush && m_pend) m_stale = 1;
      if (flush) m_addr = flush_addr;
      else if (acc) m_addr = m_addr + (m_addr[0] ? 20'd1 : 20'd2);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule